// File: doc/BRIEF.md
# APB Interval Timer

A memory-mapped down-counting timer with a configurable number of channels (two by default) behind an APB slave port. Each channel holds a control word, a reload value and a live count. Once enabled, a channel counts down by one on every count tick. The tick is either every APB clock cycle or a per-channel external tick-enable pulse that is already synchronous to the APB clock. When the count is already zero, the next tick wraps it back to the reload value and raises the channel's sticky status bit. Because of this, a reload value of N gives an event every N+1 ticks.

The control word carries a width mode. The mode selects whether all 32 reload bits are used, or only the low 16 or the low 8. Status, interrupt enable and channel enable are each one shared register. A channel's bits in those registers sit four positions apart, so channel c owns bit 4c. The interrupt line is high while any channel has both its status bit and its enable bit set. Software reads the live count at any time; inverting it gives an up-counting time base. Software clears status by writing ones.

The port is zero-wait: PREADY is always high and PSLVERR is always low. Read data is driven combinationally from the address during the access.

Top module: `apb_interval_timer`

## Requirements
- R1: After reset, every control, reload, count, enable and status register reads zero and `irq` is low.
- R2: Offset 0x00 reads the `ID_VALUE` parameter. Offset 0x10 reads the channel count `NUM_CH`. Writes to either offset leave the value unchanged.
- R3: Shared registers sit at fixed offsets: interrupt enable at 0x14, status at 0x18 and channel enable at 0x1C, with channel c owning bit 4c of each. Channel c has control at 0x20+0x10·c, reload at 0x24+0x10·c and the read-only live count at 0x28+0x10·c.
- R4: A write that changes a channel's enable bit from 0 to 1 loads the count with the reload value, masked to the mode width. Each following tick lowers the count by one, and the count is readable at any time.
- R5: A tick that finds the count at zero reloads it and sets the status bit. The first event therefore comes reload+1 ticks after the start, and later events come every reload+1 ticks.
- R6: Control bits [2:0] select the width: 1 uses all 32 bits, 2 uses bits [15:0], 3 uses bits [7:0]. Any other value keeps the count at zero and never sets status.
- R7: Control bit 3 selects the tick source. A 1 ticks every APB clock cycle. A 0 ticks only in cycles where that channel's `ext_tick` bit is high.
- R8: Clearing the enable bit freezes the count. A reload value rewritten while the channel is disabled is used from the next start.
- R9: Status bits are sticky and set whether or not their interrupt enable is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a wrap and a clear of the same bit fall in one cycle, the bit ends set.
- R10: `irq` is high exactly when some channel has both its status bit and its interrupt enable bit at 1.
- R11: Unmapped offsets (for example 0x08, 0x0C, 0x2C) read zero and ignore writes. Writes to a count register are ignored. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock, also the fast count tick |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high (zero-wait) |
| pslverr | output | 1 | Always low |
| ext_tick | input | NUM_CH | Per-channel synchronous external tick enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps both channels across the three width modes. For each combination it uses reload values whose high bits are set or clear, so a width mask that is wrong or missing changes the measured event latency. It times the first event, which separates the start-load behaviour from the wrap period. It times the second event after a clear, which shows the period really is reload+1. It then applies sparse external tick pulses against a free-running clock to show the tick source selection. A clear that lands in the same cycle as a wrap shows that the set takes priority. Reads of the live count at known cycle offsets, before and after disabling the channel, tell a frozen count apart from one still running.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned LANE = 4;   // bit distance between channels in shared registers

  typedef enum logic [2:0] {
    MODE_OFF = 3'd0,
    MODE_W32 = 3'd1,
    MODE_W16 = 3'd2,
    MODE_W8  = 3'd3
  } cnt_mode_e;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_CFG    = 8'h10;
  localparam logic [7:0] OFF_IEN    = 8'h14;
  localparam logic [7:0] OFF_STS    = 8'h18;
  localparam logic [7:0] OFF_CEN    = 8'h1C;
  localparam logic [7:0] OFF_CH0    = 8'h20;
  localparam logic [7:0] CH_STRIDE  = 8'h10;
  localparam logic [7:0] SUB_CTRL   = 8'h00;
  localparam logic [7:0] SUB_RELOAD = 8'h04;
  localparam logic [7:0] SUB_COUNT  = 8'h08;

  function automatic logic [DW-1:0] width_mask(input logic [2:0] mode);
    case (cnt_mode_e'(mode))
      MODE_W32: return {DW{1'b1}};
      MODE_W16: return DW'(32'h0000_FFFF);
      MODE_W8:  return DW'(32'h0000_00FF);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [7:0] chan_addr(input int unsigned c, input logic [7:0] sub);
    return 8'(OFF_CH0 + CH_STRIDE * 8'(c) + sub);
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ctrl,      // [3] tick source, [2:0] width mode
  input  logic [DW-1:0] reload,
  input  logic          en,
  input  logic          start,
  input  logic          ext_tick,
  output logic [DW-1:0] count,
  output logic          wrap
);
  logic [DW-1:0] mask;
  logic          tick;
  logic          active;

  assign mask   = width_mask(ctrl[2:0]);
  assign tick   = ctrl[3] ? 1'b1 : ext_tick;
  assign active = en & tick & (mask != '0);
  assign wrap   = active & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= reload & mask;
    end else if (active) begin
      if (count == '0) count <= reload & mask;
      else             count <= (count - 1'b1) & mask;
    end
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wrap,
  input  logic [NUM_CH-1:0] clr,
  input  logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] sts,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | wrap;   // a wrap outranks a same-cycle clear
  end

  assign irq = |(sts & ien);
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A17_0100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DW-1:0]              pwdata,
  output logic [DW-1:0]              prdata,
  output logic [NUM_CH-1:0][3:0]     ch_ctrl,
  output logic [NUM_CH-1:0][DW-1:0]  ch_reload,
  output logic [NUM_CH-1:0]          ch_en,
  output logic [NUM_CH-1:0]          ch_start,
  output logic [NUM_CH-1:0]          irq_en,
  output logic [NUM_CH-1:0]          sts_clr,
  input  logic [NUM_CH-1:0][DW-1:0]  ch_count,
  input  logic [NUM_CH-1:0]          sts
);
  logic              wr;
  logic              hit_id, hit_cfg, hit_ien, hit_sts, hit_cen;
  logic [NUM_CH-1:0] hit_ctrl, hit_rel, hit_cnt, lane;

  assign wr      = psel & penable & pwrite;
  assign hit_id  = (paddr == ADDR_W'(OFF_ID));
  assign hit_cfg = (paddr == ADDR_W'(OFF_CFG));
  assign hit_ien = (paddr == ADDR_W'(OFF_IEN));
  assign hit_sts = (paddr == ADDR_W'(OFF_STS));
  assign hit_cen = (paddr == ADDR_W'(OFF_CEN));

  function automatic logic [DW-1:0] pack_lanes(input logic [NUM_CH-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    for (int c = 0; c < NUM_CH; c++) r[LANE*c] = v[c];
    return r;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit_ctrl[c] = (paddr == ADDR_W'(chan_addr(c, SUB_CTRL)));
    assign hit_rel[c]  = (paddr == ADDR_W'(chan_addr(c, SUB_RELOAD)));
    assign hit_cnt[c]  = (paddr == ADDR_W'(chan_addr(c, SUB_COUNT)));
    assign lane[c]     = pwdata[LANE*c];
    assign ch_start[c] = wr & hit_cen & lane[c] & ~ch_en[c];
    assign sts_clr[c]  = wr & hit_sts & lane[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctrl[c]   <= '0;
        ch_reload[c] <= '0;
      end else if (wr) begin
        if (hit_ctrl[c]) ch_ctrl[c]   <= pwdata[3:0];
        if (hit_rel[c])  ch_reload[c] <= pwdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en  <= '0;
      irq_en <= '0;
    end else if (wr) begin
      if (hit_cen) ch_en  <= lane;
      if (hit_ien) irq_en <= lane;
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_id)       prdata = ID_VALUE;
    else if (hit_cfg) prdata = DW'(NUM_CH);
    else if (hit_ien) prdata = pack_lanes(irq_en);
    else if (hit_sts) prdata = pack_lanes(sts);
    else if (hit_cen) prdata = pack_lanes(ch_en);
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_ctrl[c]) prdata = DW'(ch_ctrl[c]);
      if (hit_rel[c])  prdata = ch_reload[c];
      if (hit_cnt[c])  prdata = ch_count[c];
    end
  end
endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A17_0100
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NUM_CH-1:0] ext_tick,
  output logic              irq
);
  logic [NUM_CH-1:0][3:0]    ch_ctrl;
  logic [NUM_CH-1:0][DW-1:0] ch_reload;
  logic [NUM_CH-1:0][DW-1:0] ch_count;
  logic [NUM_CH-1:0]         ch_en, ch_start, irq_en, sts_clr, sts_q, wrap;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ch_ctrl(ch_ctrl), .ch_reload(ch_reload), .ch_en(ch_en), .ch_start(ch_start),
    .irq_en(irq_en), .sts_clr(sts_clr), .ch_count(ch_count), .sts(sts_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tmr_channel u_chan (
      .clk(pclk), .rst_n(presetn), .ctrl(ch_ctrl[c]), .reload(ch_reload[c]),
      .en(ch_en[c]), .start(ch_start[c]), .ext_tick(ext_tick[c]),
      .count(ch_count[c]), .wrap(wrap[c])
    );
  end

  tmr_status #(.NUM_CH(NUM_CH)) u_status (
    .clk(pclk), .rst_n(presetn), .wrap(wrap), .clr(sts_clr), .ien(irq_en),
    .sts(sts_q), .irq(irq)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      psel,
  input logic                      pwrite,
  input logic [ADDR_W-1:0]         paddr,
  input logic [DW-1:0]             prdata,
  input logic                      irq,
  input logic [NUM_CH-1:0][3:0]    ctrl,
  input logic [NUM_CH-1:0][DW-1:0] reload,
  input logic [NUM_CH-1:0][DW-1:0] cnt,
  input logic [NUM_CH-1:0]         en,
  input logic [NUM_CH-1:0]         start,
  input logic [NUM_CH-1:0]         clr,
  input logic [NUM_CH-1:0]         ien,
  input logic [NUM_CH-1:0]         sts
);
  logic mapped;
  always_comb begin
    mapped = (paddr == ADDR_W'(OFF_ID))  || (paddr == ADDR_W'(OFF_CFG)) ||
             (paddr == ADDR_W'(OFF_IEN)) || (paddr == ADDR_W'(OFF_STS)) ||
             (paddr == ADDR_W'(OFF_CEN));
    for (int c = 0; c < NUM_CH; c++)
      if ((paddr == ADDR_W'(chan_addr(c, SUB_CTRL))) ||
          (paddr == ADDR_W'(chan_addr(c, SUB_RELOAD))) ||
          (paddr == ADDR_W'(chan_addr(c, SUB_COUNT)))) mapped = 1'b1;
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && !mapped) |-> (prdata == '0)); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien & sts) != '0)); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |=> (cnt[c] == ($past(reload[c]) & width_mask($past(ctrl[c][2:0]))))); // R4

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[c] && !start[c]) |=> $stable(cnt[c])); // R8

    AST_WRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && ctrl[c][3] && (width_mask(ctrl[c][2:0]) != '0) && (cnt[c] == '0)) |=> sts[c]); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[c] && !clr[c]) |=> sts[c]); // R9
  end
endmodule

bind apb_interval_timer tmr_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(pclk), .rst_n(presetn), .psel(psel), .pwrite(pwrite), .paddr(paddr),
  .prdata(prdata), .irq(irq), .ctrl(ch_ctrl), .reload(ch_reload), .cnt(ch_count),
  .en(ch_en), .start(ch_start), .clr(sts_clr), .ien(irq_en), .sts(sts_q)
);

// File: tb/apb_interval_timer_tb_top.sv
`timescale 1ns/1ps
module apb_interval_timer_tb_top;
  localparam logic [31:0] TB_ID = 32'h5EED_0042;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  logic [1:0]  ext_tick = '0;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic rd_ready, rd_err;

  always #2.5 pclk = ~pclk;

  apb_interval_timer #(.NUM_CH(2), .ADDR_W(8), .ID_VALUE(TB_ID)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ext_tick(ext_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge pclk); @(negedge pclk);
    penable = 1;
    @(posedge pclk); @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge pclk); @(negedge pclk);
    penable = 1;
    #1 d = prdata; rd_ready = pready; rd_err = pslverr;
    @(posedge pclk); @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_irq(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge pclk); @(negedge pclk);
      if (irq) begin k = i; break; end
    end
  endtask

  task automatic pulse_ext(input int ch, input int n);
    ext_tick[ch] = 1'b1;
    repeat (n) @(posedge pclk);
    @(negedge pclk);
    ext_tick[ch] = 1'b0;
  endtask

  function automatic int eff_reload(input int mode, input logic [31:0] rv);
    if (mode == 1) return int'(rv);
    if (mode == 2) return int'(rv % 32'd65536);
    return int'(rv % 32'd256);
  endfunction

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int k;
    logic [31:0] vals [5] = '{32'd0, 32'd2, 32'd7, 32'h0000_0105, 32'h0003_0006};

    repeat (4) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    apb_rd(8'h14, d); chk("R1 ien reset", d, 0);
    apb_rd(8'h18, d); chk("R1 status reset", d, 0);
    apb_rd(8'h1C, d); chk("R1 enable reset", d, 0);
    apb_rd(8'h28, d); chk("R1 count0 reset", d, 0);
    apb_rd(8'h34, d); chk("R1 reload1 reset", d, 0);

    // R2 identity and configuration
    apb_rd(8'h00, d); chk("R2 id value", d, TB_ID);
    apb_wr(8'h00, 32'h0);
    apb_rd(8'h00, d); chk("R2 id not writable", d, TB_ID);
    apb_rd(8'h10, d); chk("R2 channel count", d, 32'd2);

    // R11 unmapped offsets
    apb_rd(8'h08, d); chk("R11 unmapped 0x08 read", d, 0);
    chk("R11 pready high", {31'd0, rd_ready}, 32'd1);
    chk("R11 pslverr low", {31'd0, rd_err}, 32'd0);
    apb_wr(8'h0C, 32'hFFFF_FFFF);
    apb_rd(8'h0C, d); chk("R11 unmapped 0x0C write ignored", d, 0);
    apb_wr(8'h2C, 32'h1234_5678);
    apb_rd(8'h2C, d); chk("R11 unmapped 0x2C write ignored", d, 0);

    // R3 R4 R5 R6 R10: sweep of channels, widths and reload values
    for (int ch = 0; ch < 2; ch++) begin
      for (int mode = 1; mode <= 3; mode++) begin
        for (int vi = 0; vi < 5; vi++) begin
          int eff;
          logic [7:0] base;
          logic [31:0] lane;
          eff  = eff_reload(mode, vals[vi]);
          if (eff > 1000) continue;
          base = 8'(8'h20 + 8'h10 * ch);
          lane = 32'd1 << (4 * ch);
          apb_wr(8'h1C, 32'h0);
          apb_wr(8'h18, 32'hFFFF_FFFF);
          apb_wr(8'h14, lane);
          apb_wr(base, 32'h8 | 32'(mode));
          apb_wr(base + 8'h4, vals[vi]);
          apb_wr(8'h1C, lane);
          wait_irq(2000, k);
          chk($sformatf("R5 R6 first event ch%0d mode%0d reload%0h", ch, mode, vals[vi]),
              32'(k), 32'(eff + 1));
          if (eff >= 2) begin
            apb_wr(8'h18, lane);
            chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
            wait_irq(2000, k);
            chk($sformatf("R5 period ch%0d mode%0d", ch, mode), 32'(k), 32'(eff - 1));
            apb_rd(8'h18, d);
            chk($sformatf("R3 status lane ch%0d", ch), d, lane);
          end
        end
      end
    end

    // R6 unsupported modes never count
    for (int m = 0; m < 8; m += 4) begin
      for (int j = 0; j < 2; j++) begin
        int mv;
        mv = (j == 0) ? m : m + 3;   // 0,3 -> 0 and 3 is legal, so use 0,4,7
        if (mv == 3) continue;
        apb_wr(8'h1C, 32'h0);
        apb_wr(8'h18, 32'hFFFF_FFFF);
        apb_wr(8'h20, 32'h8 | 32'(mv));
        apb_wr(8'h24, 32'd3);
        apb_wr(8'h1C, 32'h1);
        repeat (10) @(negedge pclk);
        apb_rd(8'h18, d); chk($sformatf("R6 mode %0d no status", mv), d, 0);
        apb_rd(8'h28, d); chk($sformatf("R6 mode %0d count zero", mv), d, 0);
      end
    end

    // R4 live count, R8 freeze and deferred reload, R11 count read-only
    apb_wr(8'h1C, 32'h0);
    apb_wr(8'h18, 32'hFFFF_FFFF);
    apb_wr(8'h14, 32'h0);
    apb_wr(8'h20, 32'h9);
    apb_wr(8'h24, 32'd1000);
    apb_wr(8'h1C, 32'h1);
    apb_rd(8'h28, d);  chk("R4 live count first read", d, 32'd999);
    apb_rd(8'h28, d);  chk("R4 live count second read", d, 32'd997);
    apb_wr(8'h1C, 32'h0);
    apb_rd(8'h28, d);  chk("R8 count frozen value", d, 32'd994);
    apb_rd(8'h28, d2); chk("R8 count stays frozen", d2, 32'd994);
    apb_wr(8'h28, 32'h55);
    apb_rd(8'h28, d);  chk("R11 count write ignored", d, 32'd994);
    apb_wr(8'h24, 32'd4);
    apb_wr(8'h14, 32'h1);
    apb_wr(8'h1C, 32'h1);
    wait_irq(100, k);  chk("R8 new reload on restart", 32'(k), 32'd5);

    // R7 external tick on channel 1, R9 status without enable, R10 irq gating
    apb_wr(8'h1C, 32'h0);
    apb_wr(8'h18, 32'hFFFF_FFFF);
    apb_wr(8'h14, 32'h0);
    apb_wr(8'h30, 32'h1);
    apb_wr(8'h34, 32'd10);
    apb_wr(8'h1C, 32'h10);
    apb_rd(8'h38, d);  chk("R7 no tick without ext pulse", d, 32'd10);
    apb_rd(8'h38, d);  chk("R7 still held", d, 32'd10);
    pulse_ext(1, 4);
    apb_rd(8'h38, d);  chk("R7 four ext ticks", d, 32'd6);
    pulse_ext(1, 7);
    apb_rd(8'h38, d);  chk("R5 wrap via ext ticks reloads", d, 32'd10);
    apb_rd(8'h18, d);  chk("R9 status set with enable clear", d, 32'h10);
    chk("R10 irq low when enable clear", {31'd0, irq}, 32'd0);
    apb_wr(8'h14, 32'h10);
    chk("R10 irq high after enable", {31'd0, irq}, 32'd1);
    apb_wr(8'h18, 32'h0);
    apb_rd(8'h18, d);  chk("R9 zero write keeps status", d, 32'h10);
    chk("R10 irq still high", {31'd0, irq}, 32'd1);
    apb_wr(8'h18, 32'h10);
    apb_rd(8'h18, d);  chk("R9 one write clears status", d, 32'h0);
    chk("R10 irq low after clear", {31'd0, irq}, 32'd0);

    // R9 wrap and clear in the same cycle: set wins
    pulse_ext(1, 10);
    apb_rd(8'h38, d);  chk("R7 count at zero", d, 32'd0);
    psel = 1; pwrite = 1; paddr = 8'h18; pwdata = 32'h10; penable = 0;
    @(posedge pclk); @(negedge pclk);
    penable = 1; ext_tick[1] = 1'b1;
    @(posedge pclk); @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; ext_tick[1] = 1'b0;
    apb_rd(8'h18, d);  chk("R9 set wins over clear", d, 32'h10);
    apb_rd(8'h38, d);  chk("R5 reload after same-cycle wrap", d, 32'd10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule